// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block gathers 32 level-sensitive interrupt sources into one shared raw vector and drives two outputs from it: a normal-priority request and a fast request. Each output has its own enable mask. An output is high while at least one raw source is high and enabled for that output. No edge detection, priority encoding or vector generation is done. Software sees the state and changes the masks through a small word-addressed register window. Writes update on the clock edge, and reads return data combinationally in the same cycle.

Source 0 can also be raised by software. A register bit is set and cleared through two dedicated words, and that bit is ORed with external input 0. Both outputs are plain level signals, so a second instance can feed its request output into a source input of a first instance, for example source 26, to cascade two controllers.

Top module: `irq_fiq_ctrl`

## Requirements
- R1: Words 1 and 9 both read back the raw level vector in the same cycle the source inputs are presented. Bit n of the vector is source input n, and bit 0 also includes the software bit.
- R2: Word 0 reads raw level AND normal-output enable mask. Word 8 reads raw level AND fast-output enable mask.
- R3: A write to word 2 ORs the data into the normal-output mask. A write to word 3 clears every mask bit where the data is one. Word 2 reads the mask back, and the change is visible from the cycle after the write.
- R4: Words 10 and 11 set and clear the fast-output mask in the same way, and word 10 reads it back.
- R5: A write to word 4 with data bit 0 set sets the software bit. A write to word 5 with data bit 0 set clears it. Writes to either word with data bit 0 at zero leave it unchanged. Word 4 reads raw source 0 in bit 0 and zero elsewhere.
- R6: Raw source 0 is high when external input 0 is high, when the software bit is set, or when both are.
- R7: `irq_o` is high exactly when some bit of raw level AND the normal mask is one, in the same cycle.
- R8: `fiq_o` is high exactly when some bit of raw level AND the fast mask is one, in the same cycle.
- R9: Reads of words 3, 5 and 11 and of any unmapped word return zero. Writes to words 0, 1, 8 and 9 or to unmapped words change no state.
- R10: While reset is low, both masks and the software bit are zero and both outputs are low. Reset is asynchronous and active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lvl | input | NSRC (32) | Source levels, one bit per source |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| addr | input | AW (6) | Word index of the access |
| wdata | input | NSRC (32) | Write data |
| rdata | output | NSRC (32) | Read data for the word at `addr`, combinational |
| irq_o | output | 1 | Normal-priority request, level |
| fiq_o | output | 1 | Fast request, level |

## Verification
Two overlaps can fall in the same cycle. A write to the software-set word can arrive while external input 0 falls. A mask-enable write can arrive for a source that rises in that same cycle, which is how a cascaded request on source 26 shows up. The bench forces both overlaps with directed steps, and then runs a randomized stream that mixes writes and source changes on every cycle. Every cycle, a behavioural model that holds the masks and the software bit predicts the read data and both outputs from the pre-edge state. Each prediction is compared before the next edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    // Each output owns a group of words; the fast group sits one stride above.
    localparam int IRQC_NOUT       = 2;
    localparam int IRQC_GRP_STRIDE = 8;
    localparam int IRQC_OFS_MASKED = 0;
    localparam int IRQC_OFS_RAW    = 1;
    localparam int IRQC_OFS_EN_SET = 2;
    localparam int IRQC_OFS_EN_CLR = 3;
    // Software source words (shared, not per group).
    localparam int IRQC_SOFT_SET_W = 4;
    localparam int IRQC_SOFT_CLR_W = 5;

    typedef struct packed {
        logic set;
        logic clr;
    } irqc_wr_dec_t;
endpackage

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_en,
    input  logic            clr_en,
    input  logic [NSRC-1:0] wdata,
    output logic [NSRC-1:0] mask_q
);
    logic [NSRC-1:0] set_bits;
    logic [NSRC-1:0] clr_bits;

    assign set_bits = set_en ? wdata : '0;
    assign clr_bits = clr_en ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (set_en || clr_en) begin
            mask_q <= (mask_q | set_bits) & ~clr_bits;
        end
    end
endmodule

// File: rtl/irqc_soft_src.sv
module irqc_soft_src (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic soft_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            soft_q <= 1'b0;
        end else if (set_req) begin
            soft_q <= 1'b1;
        end else if (clr_req) begin
            soft_q <= 1'b0;
        end
    end
endmodule

// File: rtl/irqc_rd_mux.sv
module irqc_rd_mux
    import irqc_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int AW   = 6,
    parameter int NOUT = IRQC_NOUT
) (
    input  logic [AW-1:0]                addr,
    input  logic [NSRC-1:0]              raw_lvl,
    input  logic [NOUT-1:0][NSRC-1:0]    en_mask,
    output logic [NSRC-1:0]              rdata
);
    always_comb begin
        rdata = '0;
        for (int g = 0; g < NOUT; g++) begin
            if (addr == AW'(g*IRQC_GRP_STRIDE + IRQC_OFS_MASKED)) begin
                rdata = raw_lvl & en_mask[g];
            end
            if (addr == AW'(g*IRQC_GRP_STRIDE + IRQC_OFS_RAW)) begin
                rdata = raw_lvl;
            end
            if (addr == AW'(g*IRQC_GRP_STRIDE + IRQC_OFS_EN_SET)) begin
                rdata = en_mask[g];
            end
        end
        if (addr == AW'(IRQC_SOFT_SET_W)) begin
            rdata = {{(NSRC-1){1'b0}}, raw_lvl[0]};
        end
    end
endmodule

// File: rtl/irq_fiq_ctrl.sv
module irq_fiq_ctrl
    import irqc_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int AW   = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_lvl,
    input  logic            wr_en,
    input  logic [AW-1:0]   addr,
    input  logic [NSRC-1:0] wdata,
    output logic [NSRC-1:0] rdata,
    output logic            irq_o,
    output logic            fiq_o
);
    localparam int NOUT = IRQC_NOUT;

    logic                         soft_q;
    logic [NSRC-1:0]              raw_lvl;
    logic [NOUT-1:0][NSRC-1:0]    en_q;
    logic [NOUT-1:0]              line;

    assign raw_lvl = src_lvl | NSRC'(soft_q);

    for (genvar g = 0; g < NOUT; g++) begin : g_out
        irqc_wr_dec_t dec;
        assign dec.set = wr_en && (addr == AW'(g*IRQC_GRP_STRIDE + IRQC_OFS_EN_SET));
        assign dec.clr = wr_en && (addr == AW'(g*IRQC_GRP_STRIDE + IRQC_OFS_EN_CLR));

        irqc_mask_reg #(.NSRC(NSRC)) u_mask (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_en (dec.set),
            .clr_en (dec.clr),
            .wdata  (wdata),
            .mask_q (en_q[g])
        );

        assign line[g] = |(raw_lvl & en_q[g]);
    end

    irqc_soft_src u_soft (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (wr_en && (addr == AW'(IRQC_SOFT_SET_W)) && wdata[0]),
        .clr_req (wr_en && (addr == AW'(IRQC_SOFT_CLR_W)) && wdata[0]),
        .soft_q  (soft_q)
    );

    irqc_rd_mux #(.NSRC(NSRC), .AW(AW), .NOUT(NOUT)) u_rd (
        .addr    (addr),
        .raw_lvl (raw_lvl),
        .en_mask (en_q),
        .rdata   (rdata)
    );

    assign irq_o = line[0];
    assign fiq_o = line[1];
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
    parameter int NSRC = 32,
    parameter int AW   = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [AW-1:0]   addr,
    input logic [NSRC-1:0] wdata,
    input logic            irq_o,
    input logic            fiq_o,
    input logic [NSRC-1:0] irq_en,
    input logic [NSRC-1:0] fiq_en,
    input logic            soft_q
);
    // R3
    irq_en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == AW'(2) |=> (irq_en & $past(wdata)) == $past(wdata));
    // R3
    irq_en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == AW'(3) |=> (irq_en & $past(wdata)) == '0);
    // R4
    fiq_en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == AW'(10) |=> (fiq_en & $past(wdata)) == $past(wdata));
    // R5
    soft_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == AW'(4) && wdata[0] |=> soft_q);
    // R7
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == AW'(3) && (&wdata) |=> !irq_o);
    // R8
    fiq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == AW'(11) && (&wdata) |=> !fiq_o);
    // R9
    ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (addr == AW'(0) || addr == AW'(1) || addr == AW'(8) || addr == AW'(9))
        |=> $stable(irq_en) && $stable(fiq_en) && $stable(soft_q));
    // R10
    rst_state_chk: assert property (@(posedge clk)
        !rst_n |-> irq_en == '0 && fiq_en == '0 && !soft_q && !irq_o && !fiq_o);
endmodule

bind irq_fiq_ctrl irqc_chk #(.NSRC(NSRC), .AW(AW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .irq_o  (irq_o),
    .fiq_o  (fiq_o),
    .irq_en (en_q[0]),
    .fiq_en (en_q[1]),
    .soft_q (soft_q)
);

// File: tb/tb_irq_fiq_ctrl.sv
module tb_irq_fiq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 32;
    localparam int AW   = 6;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NSRC-1:0] src_lvl;
    logic            wr_en;
    logic [AW-1:0]   addr;
    logic [NSRC-1:0] wdata;
    logic [NSRC-1:0] rdata;
    logic            irq_o;
    logic            fiq_o;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] m_irq;
    logic [31:0] m_fiq;
    logic        m_soft;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_fiq_ctrl #(.NSRC(NSRC), .AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    function automatic logic [31:0] m_raw(input logic [31:0] s);
        return s | {31'b0, m_soft};
    endfunction

    function automatic logic [31:0] m_read(input int a, input logic [31:0] s);
        logic [31:0] r;
        r = m_raw(s);
        case (a)
            0:  return r & m_irq;
            1:  return r;
            2:  return m_irq;
            4:  return {31'b0, r[0]};
            8:  return r & m_fiq;
            9:  return r;
            10: return m_fiq;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One bus cycle: drive at the falling edge, compare before the rising edge,
    // then advance the model across the rising edge.
    task automatic step(input string tag, input logic w, input int a,
                        input logic [31:0] d, input logic [31:0] s);
        logic [31:0] r;
        @(negedge clk);
        wr_en = w; addr = AW'(a); wdata = d; src_lvl = s;
        #1;
        r = m_raw(s);
        check({tag, " rdata"}, rdata, m_read(a, s));
        check({tag, " R7 irq_o"}, {31'b0, irq_o}, {31'b0, |(r & m_irq)});
        check({tag, " R8 fiq_o"}, {31'b0, fiq_o}, {31'b0, |(r & m_fiq)});
        @(posedge clk);
        if (w) begin
            case (a)
                2:  m_irq = m_irq | d;
                3:  m_irq = m_irq & ~d;
                10: m_fiq = m_fiq | d;
                11: m_fiq = m_fiq & ~d;
                4:  if (d[0]) m_soft = 1'b1;
                5:  if (d[0]) m_soft = 1'b0;
                default: ;
            endcase
        end
    endtask

    initial begin
        #(CLK_PERIOD*50000);
        n_chk++; n_fail++;
        $display("FAIL watchdog R10 actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; src_lvl = '0;
        m_irq = '0; m_fiq = '0; m_soft = 1'b0;
        // R10: reset state with all sources high
        @(negedge clk);
        src_lvl = '1; addr = AW'(2); #1;
        check("R10 irq_o in reset", {31'b0, irq_o}, 32'h0);
        check("R10 fiq_o in reset", {31'b0, fiq_o}, 32'h0);
        check("R10 irq mask in reset", rdata, 32'h0);
        addr = AW'(10); #1;
        check("R10 fiq mask in reset", rdata, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: raw level tracks the sources on both raw words
        step("R1", 1'b0, 1, 32'h0, 32'hA5A5_0F0F);
        step("R1", 1'b0, 9, 32'h0, 32'h8000_0002);
        // R3: set then clear bits of the normal mask
        step("R3", 1'b1, 2, 32'h0000_00F0, 32'h0);
        step("R3", 1'b0, 2, 32'h0, 32'h0);
        step("R3", 1'b1, 3, 32'h0000_0030, 32'h0);
        step("R3", 1'b0, 2, 32'h0, 32'h0);
        // R7 / R2: enabled source raises irq_o, disabled one does not
        step("R7", 1'b0, 0, 32'h0, 32'h0000_0080);
        step("R2", 1'b0, 0, 32'h0, 32'h0000_0022);
        // R4 / R8: fast mask
        step("R4", 1'b1, 10, 32'h8000_0001, 32'h0);
        step("R4", 1'b0, 10, 32'h0, 32'h0);
        step("R8", 1'b0, 8, 32'h0, 32'h8000_0000);
        step("R4", 1'b1, 11, 32'h8000_0000, 32'h8000_0000);
        step("R8", 1'b0, 8, 32'h0, 32'h8000_0000);
        // R5 / R6: software source 0
        step("R5", 1'b1, 4, 32'h0000_0002, 32'h0);
        step("R5", 1'b0, 4, 32'h0, 32'h0);
        step("R5", 1'b1, 4, 32'h0000_0001, 32'h0);
        step("R6", 1'b0, 4, 32'h0, 32'h0);
        step("R6", 1'b0, 8, 32'h0, 32'h0);
        step("R5", 1'b1, 5, 32'hFFFF_FFFE, 32'h0);
        step("R5", 1'b1, 5, 32'h0000_0001, 32'h0);
        step("R6", 1'b0, 4, 32'h0, 32'h0000_0001);
        // Same cycle: soft set while external 0 falls
        step("R6", 1'b1, 4, 32'h0000_0001, 32'h0000_0001);
        step("R6", 1'b0, 4, 32'h0, 32'h0);
        step("R5", 1'b1, 5, 32'h0000_0001, 32'h0);
        // Same cycle: enable cascade source 26 as it rises
        step("R3", 1'b1, 2, 32'h0400_0000, 32'h0400_0000);
        step("R7", 1'b0, 0, 32'h0, 32'h0400_0000);
        // R9: write-only and unmapped reads, read-only writes
        step("R9", 1'b0, 3, 32'h0, 32'hFFFF_FFFF);
        step("R9", 1'b0, 5, 32'h0, 32'hFFFF_FFFF);
        step("R9", 1'b0, 11, 32'h0, 32'hFFFF_FFFF);
        step("R9", 1'b0, 63, 32'h0, 32'hFFFF_FFFF);
        step("R9", 1'b1, 0, 32'hFFFF_FFFF, 32'h0);
        step("R9", 1'b1, 1, 32'hFFFF_FFFF, 32'h0);
        step("R9", 1'b1, 9, 32'hFFFF_FFFF, 32'h0);
        step("R9", 1'b1, 40, 32'hFFFF_FFFF, 32'h0);
        step("R9", 1'b0, 2, 32'h0, 32'h0);
        step("R9", 1'b0, 10, 32'h0, 32'h0);
        step("R9", 1'b0, 4, 32'h0, 32'h0);

        // Randomized mix of writes and source changes
        for (int i = 0; i < 400; i++) begin
            int a;
            logic [31:0] s;
            a = int'($urandom % 14);
            if (a == 12) a = 63;
            if (a == 13) a = 20;
            s = $urandom & $urandom;
            step("R2 random", 1'($urandom % 2), a, $urandom, s);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule